// File: doc/BRIEF.md
# Ping-Pong Sample Buffer Filler

This block streams sample bytes from an internal byte source into a 2048-entry sample buffer. The buffer is split into a lower half (addresses 0 to 1023) and an upper half (addresses 1024 to 2047). Each byte goes through a plain write port made of an address, a data byte and a write enable. A consumer reads the same buffer and reports, on a one-bit input, which half it is reading.

After reset the filler fills the lower half once without looking at the consumer. After that it fills the other half only once the consumer has left it. Each filled half flips the filler's target half. The target half is driven out as a status bit. A sticky ready flag rises once the first half has been completely written. The byte stored at address n is always (n + 1) mod 256.

Top module: `sample_buf_filler`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the block clears all of its state. After such an edge, `wr_en`, `wr_addr`, `wr_data`, `ready` and `target_half` all read 0.
- R2: The first write (`wr_en`=1, `wr_addr`=0, `wr_data`=1) is visible after the third rising edge at which `rst_n` is high. After the first and second such edges, `wr_en` is 0. This initial fill of the lower half ignores `cons_half`.
- R3: Every write carries the data byte (`wr_addr` + 1) mod 256.
- R4: While a half is being filled, the block makes exactly one write per clock, at consecutive addresses. Each fill is exactly 1024 writes.
- R5: One cycle after the last write of a half, `wr_en` is 0, `ready` is 1 and `target_half` has inverted. `target_half` 0 means the lower half and 1 means the upper half; it is the half the block will write next.
- R6: `ready` is 0 until the last write of the first half has completed. It then stays 1 until the next reset.
- R7: While `cons_half` equals `target_half` between fills, `wr_en` stays 0 for as long as that lasts.
- R8: When `cons_half` differs from `target_half` at a rising edge between fills, the first write of the target half becomes visible after the next rising edge.
- R9: After address 2047, the write address wraps to 0 and the lower half is filled again.
- R10: Changes of `cons_half` during a fill have no effect: the fill runs on to the end of its half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cons_half | input | 1 | Half the consumer is reading (0 lower, 1 upper) |
| wr_addr | output | 11 | Buffer write address |
| wr_data | output | 8 | Buffer write data |
| wr_en | output | 1 | Buffer write enable |
| ready | output | 1 | Sticky flag: first half has been filled |
| target_half | output | 1 | Half the filler writes next |

## Verification
The hardest states to reach are the boundaries between fills: the single cycle just after the 1024th write of a half, and the address wrap from 2047 to 0. Both lie more than a thousand cycles deep and only show up when the consumer indicator is steered at the right moments.

The stimulus is a table of phases. Each phase holds `cons_half` for a set number of clocks and states the expected number of writes, the target half and the ready flag. Phases of one clock sit right at each half boundary, so the toggle cycle, the stall and the one-cycle resume latency are each checked in isolation. One phase flips the indicator in the middle of a fill to show that it is ignored.

// File: rtl/sbf_pkg.sv
// Package: shared types of the sample buffer filler.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package sbf_pkg;

    // Sequencer phases: start-up delay, active fill, hold for consumer
    typedef enum logic [1:0] {
        FS_BOOT = 2'd0,
        FS_FILL = 2'd1,
        FS_HOLD = 2'd2
    } fill_state_e;

endpackage

// File: rtl/sbf_sequencer.sv
// Module: sbf_sequencer
// Walks the buffer address space one half at a time. After reset it waits
// START_DLY cycles and then fills the lower half unconditionally. At the end
// of each half it flips its target half and holds until the consumer
// indicator differs from that target.
// Assumes: cons_half is synchronous to clk; ADDR_W >= 2; START_DLY >= 1.
module sbf_sequencer
    import sbf_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int START_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cons_half,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              tgt_half
);

    localparam int HALF_W = ADDR_W - 1;
    localparam int DLY_W  = (START_DLY > 1) ? $clog2(START_DLY) : 1;
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(START_DLY - 1);

    fill_state_e       state_q;
    logic [DLY_W-1:0]  dly_q;
    logic [ADDR_W-1:0] cnt_q;
    logic              half_q;
    logic              half_end;

    // Detect the last address of the current half
    always_comb begin
        half_end = &cnt_q[HALF_W-1:0];
    end

    // Phase control, address counter and target-half pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_BOOT;
            dly_q   <= '0;
            cnt_q   <= '0;
            half_q  <= 1'b0;
        end else begin
            case (state_q)
                FS_BOOT: begin
                    if (dly_q == DLY_LAST) begin
                        state_q <= FS_FILL;
                    end else begin
                        dly_q <= dly_q + DLY_W'(1);
                    end
                end
                FS_FILL: begin
                    cnt_q <= cnt_q + ADDR_W'(1);
                    if (half_end) begin
                        state_q <= FS_HOLD;
                        half_q  <= ~half_q;
                    end
                end
                FS_HOLD: begin
                    if (cons_half != half_q) begin
                        state_q <= FS_FILL;
                    end
                end
                default: state_q <= FS_BOOT;
            endcase
        end
    end

    // Issue one read per cycle while filling
    always_comb begin
        rd_en    = (state_q == FS_FILL);
        rd_addr  = cnt_q;
        tgt_half = half_q;
    end

endmodule

// File: rtl/sbf_byte_source.sv
// Module: sbf_byte_source
// Counter-based model of a read-only byte store with one cycle of read
// latency. The byte at address n is (n + 1) mod 2**DATA_W. The address and
// enable are registered together with the data, so each output byte always
// belongs to its output address.
// Assumes: rd_addr is only meaningful while rd_en is high.
module sbf_byte_source #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              q_en,
    output logic [ADDR_W-1:0] q_addr,
    output logic [DATA_W-1:0] q_data
);

    logic [DATA_W-1:0] byte_val;

    // Content function of the byte store
    always_comb begin
        byte_val = DATA_W'(rd_addr) + DATA_W'(1);
    end

    // Read register: enable, address and data move as one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_en   <= 1'b0;
            q_addr <= '0;
            q_data <= '0;
        end else begin
            q_en <= rd_en;
            if (rd_en) begin
                q_addr <= rd_addr;
                q_data <= byte_val;
            end
        end
    end

endmodule

// File: rtl/sample_buf_filler.sv
// Module: sample_buf_filler (top)
// Fills a two-half sample buffer from the internal byte source. It stalls
// whenever the consumer is reading the half it would fill next, and raises
// a sticky ready flag once the first half is complete.
// Assumes: cons_half is synchronous to clk; the buffer captures a write on
// the rising edge while wr_en is high.
module sample_buf_filler #(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int START_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cons_half,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_en,
    output logic              ready,
    output logic              target_half
);

    localparam int HALF_W = ADDR_W - 1;

    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic              ready_q;
    logic              last_wr;

    sbf_sequencer #(
        .ADDR_W    (ADDR_W),
        .START_DLY (START_DLY)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cons_half (cons_half),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .tgt_half  (target_half)
    );

    sbf_byte_source #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .q_en    (wr_en),
        .q_addr  (wr_addr),
        .q_data  (wr_data)
    );

    // A write to the top entry of either half closes that half
    always_comb begin
        last_wr = wr_en && (&wr_addr[HALF_W-1:0]);
    end

    // Sticky ready, set once the closing write has been taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else if (last_wr) begin
            ready_q <= 1'b1;
        end
    end

    // Drive the ready port
    always_comb begin
        ready = ready_q;
    end

endmodule

// File: rtl/sbf_checker.sv
// Module: sbf_checker
// Temporal properties of sample_buf_filler, observed at its ports only.
// Assumes: bound to every instance of sample_buf_filler.
module sbf_checker #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cons_half,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_en,
    input logic              ready,
    input logic              target_half
);

    localparam int HALF_W = ADDR_W - 1;

    // Back-to-back writes step the address by one
    p_consecutive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + ADDR_W'(1)));

    // Data byte follows the address
    p_data_pattern_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data == DATA_W'(wr_addr) + DATA_W'(1)));

    // Once ready, ready stays until reset
    p_ready_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // Cycle after a half's last write: idle, ready, target flipped
    p_half_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (&wr_addr[HALF_W-1:0])) |=>
        (!wr_en && ready && (target_half != $past(wr_addr[ADDR_W-1]))));

    // Holding on a consumer that sits on the target half
    p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !wr_en && $past(!wr_en) && (cons_half == target_half)
         && $past(cons_half == target_half)) |=> !wr_en);

endmodule

bind sample_buf_filler sbf_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) i_sbf_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cons_half   (cons_half),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_en       (wr_en),
    .ready       (ready),
    .target_half (target_half)
);

// File: tb/test_sample_buf_filler.sv
// Bench for sample_buf_filler: a table of consumer phases walked by one
// loop, then directed reset and start-up checks.
module test_sample_buf_filler;

    localparam int PERIOD = 10;
    localparam int ADDR_W = 11;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic        cons;
        logic [11:0] cycles;
        logic [11:0] writes;
        logic        tgt;
        logic        rdy;
        logic [7:0]  req;
    } step_t;

    localparam int NSTEP = 11;
    localparam step_t STEPS [0:NSTEP-1] = '{
        '{1'b1, 12'd1023, 12'd1023, 1'b1, 1'b0, 8'd10}, // R10 indicator flips mid-fill
        '{1'b1, 12'd1,    12'd0,    1'b1, 1'b1, 8'd5 }, // R5 close of lower half
        '{1'b1, 12'd150,  12'd0,    1'b1, 1'b1, 8'd7 }, // R7 long stall
        '{1'b0, 12'd1,    12'd0,    1'b1, 1'b1, 8'd8 }, // R8 edge that releases
        '{1'b0, 12'd1024, 12'd1024, 1'b0, 1'b1, 8'd8 }, // R8 upper half fill
        '{1'b0, 12'd1,    12'd0,    1'b0, 1'b1, 8'd5 }, // R5 close of upper half
        '{1'b0, 12'd60,   12'd0,    1'b0, 1'b1, 8'd7 }, // R7 stall on lower
        '{1'b1, 12'd1,    12'd0,    1'b0, 1'b1, 8'd8 }, // R8 release
        '{1'b1, 12'd1,    12'd1,    1'b0, 1'b1, 8'd9 }, // R9 wrap to address 0
        '{1'b0, 12'd1023, 12'd1023, 1'b1, 1'b1, 8'd10}, // R10 flip during refill
        '{1'b1, 12'd30,   12'd0,    1'b1, 1'b1, 8'd7 }  // R7 stall again
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cons_half = 1'b0;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              wr_en;
    logic              ready;
    logic              target_half;

    int n_chk = 0;
    int n_err = 0;
    logic [ADDR_W-1:0] exp_addr;

    sample_buf_filler #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_sample_buf_filler (
        .clk         (clk),
        .rst_n       (rst_n),
        .cons_half   (cons_half),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_en       (wr_en),
        .ready       (ready),
        .target_half (target_half)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_idle_reset(input string req);
        chk(wr_en == 1'b0, req, "wr_en in reset", int'(wr_en), 0);
        chk(wr_addr == '0, req, "wr_addr in reset", int'(wr_addr), 0);
        chk(wr_data == '0, req, "wr_data in reset", int'(wr_data), 0);
        chk(ready == 1'b0, req, "ready in reset", int'(ready), 0);
        chk(target_half == 1'b0, req, "target_half in reset", int'(target_half), 0);
    endtask

    task automatic startup(input logic cons);
        // R2: two quiet edges, then write 0 with data 1
        rst_n = 1'b1;
        cons_half = cons;
        tick();
        chk(wr_en == 1'b0, "R2", "wr_en after 1st edge", int'(wr_en), 0);
        tick();
        chk(wr_en == 1'b0, "R2", "wr_en after 2nd edge", int'(wr_en), 0);
        tick();
        chk(wr_en == 1'b1, "R2", "wr_en after 3rd edge", int'(wr_en), 1);
        chk(wr_addr == '0, "R2", "first address", int'(wr_addr), 0);
        chk(wr_data == DATA_W'(1), "R3", "first data", int'(wr_data), 1);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) tick();
        chk_idle_reset("R1");

        // R2: the initial fill ignores a consumer sitting on the lower half
        startup(1'b0);
        exp_addr = ADDR_W'(1);

        for (int s = 0; s < NSTEP; s++) begin
            int seen;
            string tag;
            seen = 0;
            tag = $sformatf("R%0d", STEPS[s].req);
            cons_half = STEPS[s].cons;
            for (int c = 0; c < int'(STEPS[s].cycles); c++) begin
                tick();
                if (wr_en) begin
                    // R4 consecutive addresses, R9 on the wrapped one
                    chk(wr_addr == exp_addr, (exp_addr == '0) ? "R9" : "R4",
                        "write address", int'(wr_addr), int'(exp_addr));
                    chk(wr_data == DATA_W'(exp_addr) + DATA_W'(1), "R3",
                        "write data", int'(wr_data),
                        int'(DATA_W'(exp_addr) + DATA_W'(1)));
                    exp_addr = exp_addr + ADDR_W'(1);
                    seen++;
                end
            end
            chk(seen == int'(STEPS[s].writes), tag, "writes in phase",
                seen, int'(STEPS[s].writes));
            chk(target_half == STEPS[s].tgt, "R5", "target_half",
                int'(target_half), int'(STEPS[s].tgt));
            chk(ready == STEPS[s].rdy, "R6", "ready", int'(ready),
                int'(STEPS[s].rdy));
            if (STEPS[s].writes == 12'd0) begin
                chk(wr_en == 1'b0, tag, "wr_en idle at phase end", int'(wr_en), 0);
            end
        end

        // R1 and R6: reset in the middle of operation clears ready
        rst_n = 1'b0;
        tick();
        chk_idle_reset("R1");
        chk(ready == 1'b0, "R6", "ready cleared by reset", int'(ready), 0);

        // R2: start-up again with the consumer on the upper half
        startup(1'b1);
        tick();
        chk(wr_en == 1'b1 && wr_addr == ADDR_W'(1), "R4",
            "second write after restart", int'(wr_addr), 1);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule